// File: doc/BRIEF.md
# Power Mode Sequencer with SMI Request

This block steps a system between three power modes (Full-On, Sleep and Suspend). A single suspend/resume pin and two inactivity timeouts, counted in refresh ticks, drive the steps. Each transition that software must see sets a sticky cause bit and raises a level-held SMI request toward the CPU. The request stays asserted until the handler clears it through the register bus.

When the Sleep inactivity timeout expires, the block does not stop the clocks straight away. It enters a hidden Temporary-On state with the clocks running, so that the CPU can service the SMI. The readable mode still shows Sleep during this state. Suspend is entered only after software writes the cause register and a refresh tick follows. Pin edges that arrive in Temporary-On are held and acted on once Suspend is reached.

Software reaches the block through a small indexed bus with read and write strobes. Index A2h clears the SMI request. Index A4h reports the visible mode. Index A5h holds the cause bits and is cleared by any write.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is Full-On (mode code 0), `smi_req` is low, all cause bits are 0, `clk_run` is high and no pin event is pending.
- R2: In Full-On, SLEEP_TICKS refresh ticks in a row without `activity` move the block to Sleep (mode 1, `clk_run` low). The move sets cause bit 0 and raises `smi_req`. An `activity` pulse restarts the count.
- R3: In Sleep, SUSP_TICKS refresh ticks move the block to Temporary-On. There `clk_run` is high, the visible mode still reads 1 (Sleep), cause bit 1 is set and `smi_req` rises.
- R4: A write of any data to index A5h clears all cause bits. An event in the same cycle as the write leaves its own bit set.
- R5: In Temporary-On, a write to A5h arms the Suspend entry. Suspend (mode 2, `clk_run` low) is entered on the first refresh tick in a cycle after the write cycle. Ticks before the write, or in the same cycle as it, do not leave Temporary-On.
- R6: Rising pin edges seen in Temporary-On are held pending. Once Suspend is reached, a pending edge resumes to Full-On.
- R7: `smi_req` holds its level until a write of any data to index A2h. That write drops it and leaves the cause bits unchanged.
- R8: A rising pin edge in Full-On starts the move to Sleep. The visible mode stays 0 until the next refresh tick, which enters Sleep. Pin edges during this move are discarded.
- R9: A rising pin edge in Sleep or Suspend moves the block directly to Full-On. The move sets cause bit 2 and raises `smi_req`. A later pin edge starts the move to Sleep again.
- R10: Cause bits accumulate. A new event does not clear bits set by earlier events.
- R11: Reads are combinational while `reg_rd` is high. A2h returns `smi_req` in bit 0, A4h returns the mode in bits 1:0, and A5h returns the cause in bits 2:0. All other indices return 0. Writes to other indices change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| susres_pin | input | 1 | Suspend/resume pin; rising edges count |
| refresh_tick | input | 1 | One-cycle refresh strobe, the timeout time base |
| activity | input | 1 | System activity; restarts the Full-On idle count |
| reg_idx | input | 8 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data (value ignored by all registers) |
| reg_rdata | output | 8 | Read data |
| smi_req | output | 1 | Level-held SMI request |
| clk_run | output | 1 | High when system clocks run |
| mode_out | output | 2 | Visible mode: 0 Full-On, 1 Sleep, 2 Suspend |

## Verification
Directed sequences drive the timeouts with and without an interrupting activity pulse. This separates a count that restarts from one that merely pauses. Pin edges are applied in each state, so that edges discarded in transit, edges held in Temporary-On and edges acted on at once give different final modes. A cause-register write on the same cycle as a refresh tick tells a correctly deferred Suspend entry from an early one. It also shows clear-versus-set priority on the cause bits. A seeded random phase mixes writes to unrelated indices with random-valued writes to A2h and A5h. Writes to unrelated indices must change nothing, while A2h and A5h writes must clear whatever data they carry.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    ST_FULL   = 3'd0,
    ST_ENTER  = 3'd1,
    ST_SLEEP  = 3'd2,
    ST_TEMPON = 3'd3,
    ST_SUSP   = 3'd4
  } pm_state_e;

  localparam logic [1:0] VIS_FULL  = 2'd0;
  localparam logic [1:0] VIS_SLEEP = 2'd1;
  localparam logic [1:0] VIS_SUSP  = 2'd2;

  localparam logic [7:0] IDX_STAT1 = 8'hA2;
  localparam logic [7:0] IDX_MODE  = 8'hA4;
  localparam logic [7:0] IDX_CAUSE = 8'hA5;

  localparam int CAUSE_W     = 3;
  localparam int CB_SLEEP    = 0;
  localparam int CB_TEMPON   = 1;
  localparam int CB_RESUME   = 2;
endpackage

// File: rtl/pwr_pin_edge.sv
module pwr_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  always_comb begin
    sync_d = {sync_q[LAST-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rise = sync_q[LAST-1] & ~sync_q[LAST];
endmodule

// File: rtl/pwr_idle_timer.sv
module pwr_idle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = cnt_en && (cnt_q == limit - CNT_W'(1));
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int SLEEP_TICKS = 4,
  parameter int SUSP_TICKS  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_rise,
  input  logic       tick,
  input  logic       activity,
  input  logic       cause_wr,
  output logic       ev_sleep,
  output logic       ev_tempon,
  output logic       ev_resume,
  output logic       clk_run,
  output logic [1:0] mode_vis
);
  localparam int MAX_TICKS = (SLEEP_TICKS > SUSP_TICKS) ? SLEEP_TICKS : SUSP_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  pm_state_e state_q, state_d;
  logic      armed_q, armed_d;
  logic      pend_q, pend_d;
  logic      tmr_clr, tmr_en, tmr_exp;
  logic [CNT_W-1:0] tmr_limit;

  always_comb begin
    state_d   = state_q;
    armed_d   = armed_q;
    pend_d    = pend_q;
    ev_sleep  = 1'b0;
    ev_tempon = 1'b0;
    ev_resume = 1'b0;
    unique case (state_q)
      ST_FULL: begin
        armed_d = 1'b0;
        pend_d  = 1'b0;
        if (pin_rise) begin
          state_d = ST_ENTER;
        end else if (tmr_exp) begin
          state_d  = ST_SLEEP;
          ev_sleep = 1'b1;
        end
      end
      ST_ENTER: begin
        if (tick) begin
          state_d  = ST_SLEEP;
          ev_sleep = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (pin_rise) begin
          state_d   = ST_FULL;
          ev_resume = 1'b1;
        end else if (tmr_exp) begin
          state_d   = ST_TEMPON;
          ev_tempon = 1'b1;
        end
      end
      ST_TEMPON: begin
        if (pin_rise) pend_d  = 1'b1;
        if (cause_wr) armed_d = 1'b1;
        if (armed_q && tick) begin
          state_d = ST_SUSP;
          armed_d = 1'b0;
        end
      end
      ST_SUSP: begin
        if (pin_rise || pend_q) begin
          state_d   = ST_FULL;
          pend_d    = 1'b0;
          ev_resume = 1'b1;
        end
      end
      default: state_d = ST_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FULL;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      pend_q  <= pend_d;
    end
  end

  assign tmr_clr   = (state_d != state_q) || ((state_q == ST_FULL) && activity);
  assign tmr_en    = tick && ((state_q == ST_FULL) || (state_q == ST_SLEEP));
  assign tmr_limit = (state_q == ST_SLEEP) ? CNT_W'(SUSP_TICKS) : CNT_W'(SLEEP_TICKS);

  pwr_idle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tmr_clr),
    .cnt_en (tmr_en),
    .limit  (tmr_limit),
    .expire (tmr_exp)
  );

  always_comb begin
    unique case (state_q)
      ST_SLEEP, ST_TEMPON: mode_vis = VIS_SLEEP;
      ST_SUSP:             mode_vis = VIS_SUSP;
      default:             mode_vis = VIS_FULL;
    endcase
  end

  assign clk_run = (state_q == ST_FULL) || (state_q == ST_ENTER) || (state_q == ST_TEMPON);

  // R5: Temporary-On is left only through an armed tick or nowhere else
  a_r5_tempon_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TEMPON && !(armed_q && tick)) |=> (state_q == ST_TEMPON));

  // R8: pin edges during the move to Sleep do not change the state
  a_r8_transit_ignores_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ENTER && pin_rise && !tick) |=> (state_q == ST_ENTER));

  // R9: a pin edge in Sleep returns straight to Full-On
  a_r9_sleep_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && pin_rise) |=> (mode_vis == VIS_FULL && clk_run));

  // R3: the hidden state never shows in the visible mode
  a_r3_tempon_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TEMPON) |-> (mode_vis == VIS_SLEEP && clk_run));
endmodule

// File: rtl/pwr_smi_regs.sv
module pwr_smi_regs
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_idx,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  input  logic       ev_sleep,
  input  logic       ev_tempon,
  input  logic       ev_resume,
  input  logic [1:0] mode_vis,
  output logic       cause_wr,
  output logic       smi_req,
  output logic [7:0] reg_rdata
);
  logic [CAUSE_W-1:0] cause_q, cause_d, ev_vec;
  logic               smi_q, smi_d;
  logic               stat_wr;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign stat_wr  = reg_wr && (reg_idx == IDX_STAT1);
  assign cause_wr = reg_wr && (reg_idx == IDX_CAUSE);

  always_comb begin
    ev_vec             = '0;
    ev_vec[CB_SLEEP]   = ev_sleep;
    ev_vec[CB_TEMPON]  = ev_tempon;
    ev_vec[CB_RESUME]  = ev_resume;
  end

  always_comb begin
    cause_d = cause_wr ? ev_vec : (cause_q | ev_vec);
    smi_d   = smi_q;
    if (stat_wr) smi_d = 1'b0;
    if (|ev_vec) smi_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      smi_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      smi_q   <= smi_d;
    end
  end

  assign smi_req = smi_q;

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_rd) begin
      unique case (reg_idx)
        IDX_STAT1: reg_rdata = {7'b0, smi_q};
        IDX_MODE:  reg_rdata = {6'b0, mode_vis};
        IDX_CAUSE: reg_rdata = {{(8-CAUSE_W){1'b0}}, cause_q};
        default:   reg_rdata = 8'h00;
      endcase
    end
  end

  // R7: the request is a level held until a status write
  a_r7_smi_level: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_q && !stat_wr) |=> smi_q);

  // R7: every event raises the request
  a_r7_event_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sleep || ev_tempon || ev_resume) |=> smi_q);

  // R10: cause bits stay set without a cause write
  a_r10_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  // R4: a cause write leaves only bits of same-cycle events
  a_r4_cause_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_wr && !(ev_sleep || ev_tempon || ev_resume)) |=> (cause_q == '0));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int SLEEP_TICKS = 4,
  parameter int SUSP_TICKS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       susres_pin,
  input  logic       refresh_tick,
  input  logic       activity,
  input  logic [7:0] reg_idx,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       smi_req,
  output logic       clk_run,
  output logic [1:0] mode_out
);
  logic pin_rise;
  logic ev_sleep, ev_tempon, ev_resume;
  logic cause_wr;

  pwr_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (susres_pin),
    .rise  (pin_rise)
  );

  pwr_mode_fsm #(.SLEEP_TICKS(SLEEP_TICKS), .SUSP_TICKS(SUSP_TICKS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_rise  (pin_rise),
    .tick      (refresh_tick),
    .activity  (activity),
    .cause_wr  (cause_wr),
    .ev_sleep  (ev_sleep),
    .ev_tempon (ev_tempon),
    .ev_resume (ev_resume),
    .clk_run   (clk_run),
    .mode_vis  (mode_out)
  );

  pwr_smi_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_idx   (reg_idx),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .ev_sleep  (ev_sleep),
    .ev_tempon (ev_tempon),
    .ev_resume (ev_resume),
    .mode_vis  (mode_out),
    .cause_wr  (cause_wr),
    .smi_req   (smi_req),
    .reg_rdata (reg_rdata)
  );

  // R1: the visible mode code is never the unused value
  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_out != 2'd3);
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int SLP = 4;
  localparam int SUS = 3;
  localparam logic [7:0] A2 = 8'hA2;
  localparam logic [7:0] A4 = 8'hA4;
  localparam logic [7:0] A5 = 8'hA5;

  logic clk, rst_n, pin, tick, act, wr, rd;
  logic [7:0] idx, wdata, rdata;
  logic smi, crun;
  logic [1:0] mode;

  int total = 0;
  int bad = 0;
  logic [2:0] exp_cause;
  logic exp_smi;
  int seed_dummy;

  pwr_mode_ctrl #(.SLEEP_TICKS(SLP), .SUSP_TICKS(SUS)) uut (
    .clk(clk), .rst_n(rst_n), .susres_pin(pin), .refresh_tick(tick),
    .activity(act), .reg_idx(idx), .reg_wr(wr), .reg_rd(rd),
    .reg_wdata(wdata), .reg_rdata(rdata), .smi_req(smi),
    .clk_run(crun), .mode_out(mode)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [2:0] after_event(input logic [2:0] c, input int b);
    return c | (3'b1 << b);
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic t, input logic w, input logic [7:0] i, input logic [7:0] d);
    tick = t; wr = w; idx = i; wdata = d;
    @(negedge clk);
    tick = 0; wr = 0; idx = 0; wdata = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic rdreg(input logic [7:0] i, output logic [7:0] v);
    idx = i; rd = 1'b1;
    #1 v = rdata;
    rd = 1'b0; idx = 0;
  endtask

  task automatic pin_pulse();
    pin = 1'b1; cycles(5);
    pin = 1'b0; cycles(3);
  endtask

  task automatic chk_regs(input string req);
    logic [7:0] v;
    rdreg(A5, v); chk(req, v, {5'b0, exp_cause});
    rdreg(A2, v); chk(req, v, {7'b0, exp_smi});
    chk(req, smi, exp_smi);
  endtask

  task automatic clear_all();
    drive(1'b0, 1'b1, A2, 8'h3C); exp_smi = 0;
    drive(1'b0, 1'b1, A5, 8'hC3); exp_cause = 0;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog got=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    seed_dummy = $urandom(32'h5EED_0042);
    pin = 0; tick = 0; act = 0; wr = 0; rd = 0; idx = 0; wdata = 0;
    exp_cause = 0; exp_smi = 0;
    rst_n = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);

    // R1 reset state
    chk("R1", mode, 0);
    chk("R1", crun, 1);
    chk_regs("R1");
    // R11 read map
    rdreg(8'h10, v); chk("R11", v, 0);
    rdreg(A4, v);    chk("R11", v, 0);
    chk("R11", rdata, 0);

    // R2 idle timeout, activity restarts the count
    ticks(SLP - 1);
    act = 1; cycles(1); act = 0;
    ticks(SLP - 1);
    chk("R2", mode, 0);
    ticks(1);
    exp_cause = after_event(exp_cause, 0); exp_smi = 1;
    chk("R2", mode, 1);
    chk("R2", crun, 0);
    chk_regs("R2");
    rdreg(A4, v); chk("R11", v, 1);

    // R7 level held, cleared by A2 write of any value
    cycles(5);
    chk("R7", smi, 1);
    drive(1'b0, 1'b1, A2, 8'($urandom)); exp_smi = 0;
    chk_regs("R7");

    // R3 Sleep timeout into Temporary-On; R4 same-cycle clear and set
    ticks(SUS - 1);
    chk("R3", mode, 1);
    chk("R3", crun, 0);
    drive(1'b1, 1'b1, A5, 8'h77);
    exp_cause = after_event(3'b000, 1); exp_smi = 1;
    chk("R3", crun, 1);
    chk("R3", mode, 1);
    rdreg(A4, v); chk("R3", v, 1);
    chk_regs("R4");

    // R6 pin edge held in Temporary-On
    pin_pulse();
    chk("R6", mode, 1);
    chk("R6", crun, 1);
    // R5 tick without write does not leave Temporary-On
    ticks(1);
    chk("R5", crun, 1);
    chk("R5", mode, 1);
    drive(1'b0, 1'b1, A5, 8'($urandom)); exp_cause = 0;
    chk_regs("R4");
    cycles(2);
    chk("R5", crun, 1);
    ticks(1);
    chk("R5", mode, 2);
    chk("R5", crun, 0);
    cycles(1);
    exp_cause = after_event(exp_cause, 2); exp_smi = 1;
    chk("R6", mode, 0);
    chk("R6", crun, 1);
    chk_regs("R6");

    // R8 move to Sleep, extra pin edges discarded
    clear_all();
    pin_pulse();
    chk("R8", mode, 0);
    chk("R8", crun, 1);
    pin_pulse();
    chk("R8", mode, 0);
    ticks(1);
    exp_cause = after_event(exp_cause, 0); exp_smi = 1;
    chk("R8", mode, 1);
    cycles(5);
    chk("R8", mode, 1);
    chk_regs("R8");

    // R9 resume from Sleep; R10 bits accumulate
    pin_pulse();
    exp_cause = after_event(exp_cause, 2);
    chk("R9", mode, 0);
    chk_regs("R10");
    pin_pulse();
    chk("R9", mode, 0);
    ticks(1);
    chk("R9", mode, 1);
    chk_regs("R9");

    // R5 cause write in the same cycle as a tick does not count the tick
    clear_all();
    ticks(SUS);
    exp_cause = after_event(exp_cause, 1); exp_smi = 1;
    chk("R3", crun, 1);
    drive(1'b1, 1'b1, A5, 8'h01); exp_cause = 0;
    chk("R5", mode, 1);
    chk("R5", crun, 1);
    ticks(1);
    chk("R5", mode, 2);
    chk("R5", crun, 0);
    cycles(4);
    chk("R5", mode, 2);
    // R9 resume from Suspend
    pin_pulse();
    exp_cause = after_event(exp_cause, 2);
    chk("R9", mode, 0);
    chk_regs("R9");

    // random register traffic in Full-On (R11, R4, R7)
    for (int i = 0; i < 40; i++) begin
      int sel;
      logic [7:0] ri;
      sel = int'($urandom % 3);
      ri  = 8'($urandom);
      if (ri == A2 || ri == A5) ri = ri ^ 8'h01;
      if (sel == 0) drive(1'b0, 1'b1, ri, 8'($urandom));
      else if (sel == 1) begin drive(1'b0, 1'b1, A5, 8'($urandom)); exp_cause = 0; end
      else begin drive(1'b0, 1'b1, A2, 8'($urandom)); exp_smi = 0; end
      chk("R11", mode, 0);
      chk_regs("R11");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule